// File: doc/BRIEF.md
# Eight-bit prescaled timer/counter with compare outputs

This block is an 8-bit timer/counter that a processor subsystem uses for time bases, periodic interrupts and pulse-width waveforms. A free-running clock divider produces count-enable pulses at a rate chosen by a 3-bit clock-select field. The counter steps on those pulses in one of four waveform modes: plain wrap-around, clear-on-compare, fast single-slope PWM and phase-correct dual-slope PWM.

Two compare channels each hold a value that the count is matched against. A match, or the counter reaching its bottom, raises a sticky event flag. A flag is turned into an interrupt request when its mask bit and the global enable input are both high. Each channel drives a waveform pin. On a match or a wrap, the pin is set, cleared or toggled according to the channel's pin action and the count direction.

Software uses a plain single-cycle register port. A write lands on the clock edge when `reg_we` is high. The read data is combinational from `reg_addr`. The interrupt controller clears the serviced flag through `irq_ack`. The port has no back-pressure: every write is accepted on the edge where it is presented.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, every register reads 0, both waveform pins are low and no interrupt request is active. The register map is:
  - address 0: control, with waveform mode in bits 1:0, channel A pin action in bits 3:2 and channel B pin action in bits 5:4
  - address 1: clock select in bits 2:0
  - address 2: count
  - address 3: compare A
  - address 4: compare B
  - address 5: flags
  - address 6: mask
  - address 7: reads 0
- R2: With clock select 0, the count never changes, however many clocks pass.
- R3: The divider is cleared by reset and advances by one on every clock. With a ratio of N, a count step occurs on each clock where the low log2(N) bits of the divider are all ones.
  - Default table: select 1, 2, 3, 4 and 5 give ratios 1, 8, 64, 256 and 1024; selects 6 and 7 stop the counter.
  - Alternate table (ALT_TABLE=1): selects 1 to 7 give ratios 1, 8, 32, 64, 128, 256 and 1024.
- R4: In mode 0 (normal), each step adds 1. The step from 0xFF to 0x00 sets flag bit 0.
- R5: A step whose new count equals compare A sets flag bit 1. A step whose new count equals compare B sets flag bit 2.
- R6: In mode 2 (clear-on-compare), a step taken while the count equals compare A returns the count to 0.
- R7: In mode 3 (fast PWM), the count wraps from 0xFF to 0 and sets flag bit 0. Pin action 2 clears the pin on a match and sets it on the wrap. Pin action 3 does the opposite. A match wins over a wrap on the same step.
- R8: In mode 1 (phase-correct), the count climbs to 0xFF and then descends. Flag bit 0 is set only on the step from 1 down to 0. From 0, the next step is 1.
- R9: In mode 1, pin action 2 clears the pin on a match made by an upward step and sets it on a match made by a downward step. Pin action 3 does the opposite. A match whose new count is 0xFF changes no pin.
- R10: Pin action 1 toggles the pin on every match. Pin action 0 leaves the pin unchanged. In modes 0 and 2, action 2 clears the pin on a match and action 3 sets it.
- R11: Interrupt request bit i equals flag bit i AND mask bit i AND `glob_ie`. Bit 0 is overflow, bit 1 is compare A and bit 2 is compare B.
- R12: A flag bit is cleared by writing 1 to it at address 5 or by a high `irq_ack` bit. Writing 0 leaves the bit unchanged. An event on the same edge wins over a clear.
- R13: A write to the count takes effect instead of a step on that edge, and the written value raises no compare flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 3 | Per-flag clear from the interrupt controller |
| irq_req | output | 3 | Interrupt requests: overflow, compare A, compare B |
| oc_a | output | 1 | Channel A waveform pin |
| oc_b | output | 1 | Channel B waveform pin |

## Verification
The count is driven through every clock-select code on both prescaler tables. This separates the divider ratios and shows that codes 6 and 7 stop one table but not the other. Each waveform mode then runs with compare values placed so the count crosses them: mid-range values in wrap and fast modes, and 0xFE and 0xFF in dual-slope mode. Those placements tell an upward match from a downward one and expose the top-of-count exception for pins. Flag handling is exercised with write-0, write-1, acknowledge pulses and gated global enable, and a count write made while running shows that loads override steps and raise no match.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    WAVE_NORMAL = 2'd0,
    WAVE_PHASE  = 2'd1,
    WAVE_CTC    = 2'd2,
    WAVE_FAST   = 2'd3
  } wave_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLR_UP = 2'd2,
    PIN_SET_UP = 2'd3
  } pin_e;

  localparam int ADDR_W  = 3;
  localparam int NUM_EVT = 3;
  localparam int NUM_CH  = 2;
  localparam int EVT_OVF = 0;
  localparam int EVT_CMPA = 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLK   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd6;

  // log2 of the divide ratio, or -1 when the select code stops the counter
  function automatic int prescale_shift(input logic [2:0] sel, input bit alt);
    int sh;
    if (!alt) begin
      case (sel)
        3'd1: sh = 0;
        3'd2: sh = 3;
        3'd3: sh = 6;
        3'd4: sh = 8;
        3'd5: sh = 10;
        default: sh = -1;
      endcase
    end else begin
      case (sel)
        3'd1: sh = 0;
        3'd2: sh = 3;
        3'd3: sh = 5;
        3'd4: sh = 6;
        3'd5: sh = 7;
        3'd6: sh = 8;
        3'd7: sh = 10;
        default: sh = -1;
      endcase
    end
    return sh;
  endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] low_mask;
  int               shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_W'(1);
  end

  always_comb begin
    shift    = prescale_shift(clk_sel, ALT_TABLE);
    low_mask = '0;
    tick     = 1'b0;
    if (shift >= 0) begin
      low_mask = (DIV_W'(1) << shift) - DIV_W'(1);
      tick     = ((div_q & low_mask) == low_mask);
    end
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  wave_e            wave,
  input  logic [CNT_W-1:0] cmp_a,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] nxt,
  output logic             step_down,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] BOTTOM = '0;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic dir_up_q, dir_up_d, wrap;

  always_comb begin
    nxt       = count_q + ONE;
    dir_up_d  = dir_up_q;
    step_down = 1'b0;
    wrap      = 1'b0;
    case (wave)
      WAVE_NORMAL, WAVE_FAST: wrap = (count_q == TOP);
      WAVE_CTC: begin
        if (count_q == cmp_a) nxt = BOTTOM;
        wrap = (count_q == TOP);
      end
      WAVE_PHASE: begin
        if (dir_up_q) begin
          if (count_q == TOP) begin
            nxt       = TOP - ONE;
            dir_up_d  = 1'b0;
            step_down = 1'b1;
          end
        end else if (count_q == BOTTOM) begin
          dir_up_d = 1'b1;
        end else begin
          nxt       = count_q - ONE;
          step_down = 1'b1;
          wrap      = (count_q == ONE);
        end
      end
      default: ;
    endcase
  end

  assign ovf_evt = adv & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      dir_up_q <= 1'b1;
    end else begin
      if (load)     count_q <= load_val;
      else if (adv) count_q <= nxt;
      if (wave != WAVE_PHASE) dir_up_q <= 1'b1;
      else if (adv)           dir_up_q <= dir_up_d;
    end
  end

endmodule

// File: rtl/tmr8_cmp_ch.sv
module tmr8_cmp_ch
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] nxt,
  input  logic             step_down,
  input  logic             ovf_evt,
  input  wave_e            wave,
  input  pin_e             pin_mode,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match_evt,
  output logic             pin
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic act_en, phase;

  assign phase     = (wave == WAVE_PHASE);
  assign match_evt = adv && (nxt == cmp_val);
  assign act_en    = match_evt && !(phase && nxt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (act_en) begin
      case (pin_mode)
        PIN_TOGGLE: pin <= ~pin;
        PIN_CLR_UP: pin <= phase ? step_down : 1'b0;
        PIN_SET_UP: pin <= phase ? ~step_down : 1'b1;
        default:    pin <= pin;
      endcase
    end else if (!match_evt && ovf_evt && wave == WAVE_FAST) begin
      case (pin_mode)
        PIN_CLR_UP: pin <= 1'b1;
        PIN_SET_UP: pin <= 1'b0;
        default:    pin <= pin;
      endcase
    end
  end

endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DIV_W     = 10,
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              glob_ie,
  input  logic [NUM_EVT-1:0] irq_ack,
  output logic [NUM_EVT-1:0] irq_req,
  output logic              oc_a,
  output logic              oc_b
);

  wave_e              wave_q;
  logic [2:0]         clk_sel_q;
  logic [NUM_EVT-1:0] flags_q, mask_q, set_evt, clr_req;
  logic [CNT_W-1:0]   count_q, nxt;
  logic               tick, adv, load, step_down, ovf_evt;
  pin_e               pin_mode_q [NUM_CH];
  logic [CNT_W-1:0]   cmp_q      [NUM_CH];
  logic               match_evt  [NUM_CH];
  logic               oc         [NUM_CH];

  assign load = reg_we && (reg_addr == ADDR_COUNT);
  assign adv  = tick && !load;

  tmr8_prescaler #(.DIV_W(DIV_W), .ALT_TABLE(ALT_TABLE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel_q), .tick(tick)
  );

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .load_val(reg_wdata),
    .wave(wave_q), .cmp_a(cmp_q[0]), .count_q(count_q), .nxt(nxt),
    .step_down(step_down), .ovf_evt(ovf_evt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_CMPA + ADDR_W'(ch);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[ch]      <= '0;
        pin_mode_q[ch] <= PIN_HOLD;
      end else if (reg_we) begin
        if (reg_addr == CMP_ADDR)  cmp_q[ch]      <= reg_wdata;
        if (reg_addr == ADDR_CTRL) pin_mode_q[ch] <= pin_e'(reg_wdata[2 + 2*ch +: 2]);
      end
    end

    tmr8_cmp_ch #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .adv(adv), .nxt(nxt), .step_down(step_down),
      .ovf_evt(ovf_evt), .wave(wave_q), .pin_mode(pin_mode_q[ch]),
      .cmp_val(cmp_q[ch]), .match_evt(match_evt[ch]), .pin(oc[ch])
    );
  end

  assign oc_a = oc[0];
  assign oc_b = oc[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q    <= WAVE_NORMAL;
      clk_sel_q <= '0;
      mask_q    <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_CTRL) wave_q    <= wave_e'(reg_wdata[1:0]);
      if (reg_addr == ADDR_CLK)  clk_sel_q <= reg_wdata[2:0];
      if (reg_addr == ADDR_MASK) mask_q    <= reg_wdata[NUM_EVT-1:0];
    end
  end

  assign set_evt = {match_evt[1], match_evt[0], ovf_evt};
  assign clr_req = irq_ack |
                   ((reg_we && reg_addr == ADDR_FLAGS) ? reg_wdata[NUM_EVT-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (set_evt[i])      flags_q[i] <= 1'b1;
        else if (clr_req[i]) flags_q[i] <= 1'b0;
      end
    end
  end

  assign irq_req = flags_q & mask_q & {NUM_EVT{glob_ie}};

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:  reg_rdata = CNT_W'({pin_mode_q[1], pin_mode_q[0], wave_q});
      ADDR_CLK:   reg_rdata = CNT_W'(clk_sel_q);
      ADDR_COUNT: reg_rdata = count_q;
      ADDR_CMPA:  reg_rdata = cmp_q[0];
      ADDR_CMPB:  reg_rdata = cmp_q[1];
      ADDR_FLAGS: reg_rdata = CNT_W'(flags_q);
      ADDR_MASK:  reg_rdata = CNT_W'(mask_q);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_checks.sv
module tmr8_checks
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adv,
  input logic               load,
  input wave_e              wave,
  input logic [2:0]         clk_sel,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   cmp_a,
  input logic [NUM_EVT-1:0] flags,
  input logic [NUM_EVT-1:0] irq_ack,
  input logic               ovf_evt,
  input logic               glob_ie,
  input logic [NUM_EVT-1:0] irq_req
);

  localparam logic [CNT_W-1:0] TOP = '1;

  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !load) |=> $stable(count));

  assert_normal_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wave == WAVE_NORMAL) |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_ctc_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wave == WAVE_CTC && count == cmp_a) |=> (count == '0));

  assert_phase_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wave == WAVE_PHASE && count == TOP) |=> (count == TOP - 1'b1));

  assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[EVT_OVF] && !ovf_evt) |=> !flags[EVT_OVF]);

  assert_gie_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> (irq_req == '0));

endmodule

bind tmr8_unit tmr8_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .wave(wave_q),
  .clk_sel(clk_sel_q), .count(count_q), .cmp_a(cmp_q[0]), .flags(flags_q),
  .irq_ack(irq_ack), .ovf_evt(ovf_evt), .glob_ie(glob_ie), .irq_req(irq_req)
);

// File: tb/tb_tmr8_unit.sv
module tb_tmr8_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd2;
  logic [7:0] reg_wdata = 8'd0;
  logic       glob_ie = 1'b0;
  logic [2:0] irq_ack = 3'd0;
  logic [7:0] reg_rdata, alt_rdata;
  logic [2:0] irq_req, alt_irq;
  logic       oc_a, oc_b, alt_oc_a, alt_oc_b;

  int checks = 0;
  int fails  = 0;
  bit run    = 0;
  bit alt_en = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  tmr8_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_ie(glob_ie),
    .irq_ack(irq_ack), .irq_req(irq_req), .oc_a(oc_a), .oc_b(oc_b)
  );

  tmr8_unit #(.ALT_TABLE(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(alt_rdata), .glob_ie(glob_ie),
    .irq_ack(irq_ack), .irq_req(alt_irq), .oc_a(alt_oc_a), .oc_b(alt_oc_b)
  );

  // ---------------- behavioural reference ----------------
  int m_mode, m_oa, m_ob, m_cs, m_cnt, m_ca, m_cb, m_flag, m_mask;
  int m_up = 1, m_pa, m_pb, m_div, m_alt;

  function automatic bit ref_tick(int cs, int dv, bit alt);
    int ratio;
    if (!alt) ratio = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 64 :
                      (cs == 4) ? 256 : (cs == 5) ? 1024 : 0;
    else      ratio = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 32 :
                      (cs == 4) ? 64 : (cs == 5) ? 128 : (cs == 6) ? 256 :
                      (cs == 7) ? 1024 : 0;
    if (ratio == 0) return 1'b0;
    return (dv % ratio) == ratio - 1;
  endfunction

  function automatic int ref_pin(int p, int om, int wm, bit hit, bit down, bit wrp, int n);
    if (hit) begin
      if (wm == 1 && n == 255) return p;
      case (om)
        1: return 1 - p;
        2: return (wm == 1) ? (down ? 1 : 0) : 0;
        3: return (wm == 1) ? (down ? 0 : 1) : 1;
        default: return p;
      endcase
    end
    if (wrp && wm == 3) begin
      if (om == 2) return 1;
      if (om == 3) return 0;
    end
    return p;
  endfunction

  always @(posedge clk) begin
    int n, nup, wd;
    bit tk, ld, adv, down, ovf, ma, mb;
    if (!rst_n) begin
      m_mode = 0; m_oa = 0; m_ob = 0; m_cs = 0; m_cnt = 0; m_ca = 0; m_cb = 0;
      m_flag = 0; m_mask = 0; m_up = 1; m_pa = 0; m_pb = 0; m_div = 0; m_alt = 0;
    end else begin
      wd   = int'(reg_wdata);
      tk   = ref_tick(m_cs, m_div, 1'b0);
      ld   = reg_we && reg_addr == 3'd2;
      adv  = tk && !ld;
      n    = m_cnt; nup = m_up; down = 0; ovf = 0;
      if (adv) begin
        if (m_mode == 1) begin
          if (m_up != 0) begin
            if (m_cnt == 255) begin n = 254; nup = 0; down = 1; end
            else n = m_cnt + 1;
          end else if (m_cnt == 0) begin
            n = 1; nup = 1;
          end else begin
            n = m_cnt - 1; down = 1; ovf = (m_cnt == 1);
          end
        end else begin
          n   = (m_mode == 2 && m_cnt == m_ca) ? 0 : (m_cnt + 1) % 256;
          ovf = (m_cnt == 255);
        end
      end
      if (m_mode != 1) nup = 1;
      ma = adv && n == m_ca;
      mb = adv && n == m_cb;
      m_pa = ref_pin(m_pa, m_oa, m_mode, ma, down, ovf, n);
      m_pb = ref_pin(m_pb, m_ob, m_mode, mb, down, ovf, n);
      for (int i = 0; i < 3; i++) begin
        bit s, c;
        s = (i == 0) ? ovf : (i == 1) ? ma : mb;
        c = irq_ack[i] || (reg_we && reg_addr == 3'd5 && reg_wdata[i]);
        if (s) m_flag = m_flag | (1 << i);
        else if (c) m_flag = m_flag & ~(1 << i);
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin m_mode = wd & 3; m_oa = (wd >> 2) & 3; m_ob = (wd >> 4) & 3; end
          3'd1: m_cs = wd & 7;
          3'd3: m_ca = wd;
          3'd4: m_cb = wd;
          3'd6: m_mask = wd & 7;
          default: ;
        endcase
      end
      if (ld) m_cnt = wd;
      else if (adv) m_cnt = n;
      m_up = nup;
      if (ld) m_alt = wd;
      else if (ref_tick(m_cs_prev_alt(), m_div, 1'b1)) m_alt = (m_alt + 1) % 256;
      m_div = (m_div + 1) % 1024;
    end
  end

  // clock select seen by the alternate instance on this edge (pre-write value)
  int m_cs_alt = 0;
  function automatic int m_cs_prev_alt();
    return m_cs_alt;
  endfunction
  always @(posedge clk) begin
    if (!rst_n) m_cs_alt <= 0;
    else if (reg_we && reg_addr == 3'd1) m_cs_alt <= int'(reg_wdata[2:0]);
  end

  function automatic int ref_read(int a);
    case (a)
      0: return m_mode | (m_oa << 2) | (m_ob << 4);
      1: return m_cs;
      2: return m_cnt;
      3: return m_ca;
      4: return m_cb;
      5: return m_flag;
      6: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run) begin
      chk(tag, int'(reg_rdata), ref_read(int'(reg_addr)));
      chk(tag, int'(irq_req), glob_ie ? (m_flag & m_mask) : 0);
      chk(tag, int'(oc_a), m_pa);
      chk(tag, int'(oc_b), m_pb);
      if (alt_en && reg_addr == 3'd2) chk("R3", int'(alt_rdata), m_alt);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    reg_addr = a;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    run = 1;

    // R1: reset state
    tag = "R1";
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1", v, 0);
    end
    chk("R1", int'(oc_a), 0);
    chk("R1", int'(oc_b), 0);
    chk("R1", int'(irq_req), 0);

    // R2: stopped counter
    tag = "R2";
    wr(3'd2, 8'h37);
    idle(300, 3'd2);
    rd(3'd2, v);
    chk("R2", v, 'h37);

    // R3: every clock-select code on both tables
    tag = "R3";
    alt_en = 1;
    for (int c = 1; c < 8; c++) begin
      wr(3'd2, 8'h00);
      wr(3'd1, 8'(c));
      idle(1100, 3'd2);
    end
    alt_en = 0;
    wr(3'd1, 8'h00);

    // R4: normal wrap sets overflow flag
    tag = "R4";
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hF0);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h01);
    idle(40, 3'd5);
    wr(3'd1, 8'h00);
    rd(3'd5, v);
    chk("R4", v & 1, 1);

    // R5: compare flags
    tag = "R5";
    wr(3'd3, 8'h20);
    wr(3'd4, 8'h30);
    wr(3'd2, 8'h10);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h01);
    idle(40, 3'd5);
    wr(3'd1, 8'h00);
    rd(3'd5, v);
    chk("R5", (v >> 1) & 3, 3);

    // R6: clear-on-compare
    tag = "R6";
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h01);
    idle(30, 3'd2);
    wr(3'd1, 8'h00);
    rd(3'd2, v);
    chk("R6", int'(v <= 5), 1);

    // R7: fast PWM with both pin polarities
    tag = "R7";
    wr(3'd0, 8'h3B);
    wr(3'd3, 8'h40);
    wr(3'd4, 8'h80);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h01);
    idle(600, 3'd2);
    wr(3'd1, 8'h00);

    // R8 / R9: dual-slope counting, match at 0xFE and at the top
    tag = "R8";
    wr(3'd0, 8'h29);
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hFF);
    wr(3'd2, 8'hF0);
    wr(3'd1, 8'h01);
    idle(550, 3'd5);
    tag = "R9";
    idle(550, 3'd2);
    wr(3'd1, 8'h00);

    // R10: toggle on match
    tag = "R10";
    wr(3'd0, 8'h14);
    wr(3'd3, 8'h10);
    wr(3'd4, 8'h90);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h01);
    idle(600, 3'd2);
    wr(3'd1, 8'h00);

    // R11: interrupt gating
    tag = "R11";
    wr(3'd6, 8'h07);
    glob_ie = 1'b0;
    idle(2, 3'd5);
    chk("R11", int'(irq_req), 0);
    glob_ie = 1'b1;
    rd(3'd5, v);
    chk("R11", int'(irq_req), v & 7);
    wr(3'd6, 8'h02);
    rd(3'd5, v);
    chk("R11", int'(irq_req), v & 2);

    // R12: flag clearing
    tag = "R12";
    rd(3'd5, v0);
    wr(3'd5, 8'h00);
    rd(3'd5, v);
    chk("R12", v, v0);
    wr(3'd5, 8'h02);
    rd(3'd5, v);
    chk("R12", v, v0 & ~2);
    @(negedge clk); #1;
    irq_ack = 3'b100;
    @(negedge clk); #1;
    irq_ack = 3'b000;
    rd(3'd5, v);
    chk("R12", v, v0 & ~6);

    // R13: count write overrides a step and raises no match
    tag = "R13";
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h07);
    wr(3'd3, 8'h55);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h55);
    wr(3'd1, 8'h00);
    rd(3'd2, v);
    chk("R13", v, 'h57);
    rd(3'd5, v);
    chk("R13", (v >> 1) & 1, 0);

    run = 0;
    finish_run();
  end

endmodule